// File: doc/BRIEF.md
# RDS Lost-Synchronization Flywheel Detector

This block sits behind an RDS/RBDS block decoder and decides when group synchronization has been lost. For every received block the decoder issues a one-cycle strobe together with two status flags. One flag says whether the block's offset word arrived in the expected sequence. The other says whether the block carried errors that could not be corrected. Depending on a mode bit, one of these two flags marks the block as bad. When a programmed number of bad blocks arrives with no good block among them, the detector leaves the synchronized state and emits a one-cycle loss pulse.

The 4-bit protection setting is held in a register inside the block and is loaded through a write strobe. Its top bit picks the bad-block criterion. Its three low bits pick the run length from a non-linear set of values. After a loss, the detector stays idle until the upstream synchronizer reports, with a one-cycle pulse, that lock has been regained.

Top module: `rds_sync_flywheel`

## Requirements
- R1: After reset, `in_sync` is 0 and `loss_pulse` is 0. The setting register holds 4'b0010, which selects offset-order mode with a run of 5 blocks.
- R2: When setting bit 3 is 0, a strobed block is bad exactly when `blk_seq_ok` is 0. `blk_uncorr` has no effect in this mode.
- R3: When setting bit 3 is 1, a strobed block is bad exactly when `blk_uncorr` is 1. `blk_seq_ok` has no effect in this mode.
- R4: Setting bits [2:0] select the run length. The codes 0 through 7 give 3, 4, 5, 6, 8, 10, 12 and 16 consecutive bad blocks.
- R5: A good block received while synchronized clears the consecutive-bad count. Loss then needs a complete new run of bad blocks.
- R6: The strobe of the bad block that completes the run causes two results in the next cycle: `in_sync` goes to 0, and `loss_pulse` goes to 1 for exactly one cycle.
- R7: Block strobes received while `in_sync` is 0 are not counted and never produce a loss pulse.
- R8: `sync_acq` sets `in_sync` to 1 in the next cycle and clears the count. A block strobe in the same cycle as `sync_acq` is not counted.
- R9: A setting written with `cfg_wr` governs every later strobe. If the count already meets or exceeds the new run length, the next bad block declares loss.
- R10: Cycles without a block strobe leave the count and the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Loads `cfg_val` into the protection setting register |
| cfg_val | input | 4 | New setting: bit 3 is the criterion, bits [2:0] are the run code |
| blk_stb | input | 1 | One-cycle strobe, one per received block |
| blk_seq_ok | input | 1 | The block's offset word followed the expected order |
| blk_uncorr | input | 1 | The block had uncorrectable errors |
| sync_acq | input | 1 | One-cycle pulse: synchronization (re)acquired |
| in_sync | output | 1 | 1 while synchronized |
| loss_pulse | output | 1 | One-cycle pulse when loss is declared |

## Verification
The bench builds the block with its default 5-bit counter and a reset setting of 4'b0010. That run of five is short, so the default-mode vector walk reaches a loss, a reset of the count by a good block, and strobes ignored while lost, all within a few dozen cycles. A directed sweep writes all eight run codes under both criteria and checks each threshold one block before and at the limit. A final test loads the longest run, builds a count of ten, then drops to the shortest run to show that loss comes on the next bad block.

// File: rtl/rds_fw_pkg.sv
package rds_fw_pkg;

  localparam int RUN_W = 5;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic                uncorr_mode;
    logic [CODE_W-1:0]   run_code;
  } prot_cfg_t;

  // Run length for a 3-bit code: linear below 4, doubled above, 16 at the top.
  function automatic logic [RUN_W-1:0] run_limit(input logic [CODE_W-1:0] code);
    logic [RUN_W-1:0] c;
    c = RUN_W'(code);
    if (code[2] == 1'b0)      run_limit = c + RUN_W'(3);
    else if (code == 3'b111)  run_limit = RUN_W'(16);
    else                      run_limit = c << 1;
  endfunction

  // Bad-block criterion selected by the mode bit.
  function automatic logic is_bad(input logic uncorr_mode, input logic seq_ok,
                                  input logic uncorr);
    is_bad = uncorr_mode ? uncorr : ~seq_ok;
  endfunction

endpackage

// File: rtl/rds_fw_classify.sv
module rds_fw_classify
  import rds_fw_pkg::*;
(
  input  logic      stb,
  input  logic      armed,
  input  prot_cfg_t cfg,
  input  logic      seq_ok,
  input  logic      uncorr,
  output logic      bad_evt,
  output logic      good_evt
);
  logic counted;
  logic bad;

  always_comb begin
    counted  = stb & armed;
    bad      = is_bad(cfg.uncorr_mode, seq_ok, uncorr);
    bad_evt  = counted & bad;
    good_evt = counted & ~bad;
  end
endmodule

// File: rtl/rds_fw_runcnt.sv
module rds_fw_runcnt
  import rds_fw_pkg::*;
#(
  parameter int CNT_W = RUN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bad_evt,
  input  logic             good_evt,
  input  logic [RUN_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_inc = {1'b0, cnt} + EXT_W'(1);
    hit     = bad_evt & (cnt_inc >= EXT_W'(limit));
    if (clr || hit || good_evt) cnt_d = '0;
    else if (bad_evt)           cnt_d = cnt_inc[CNT_W-1:0];
    else                        cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/rds_fw_state.sv
module rds_fw_state (
  input  logic clk,
  input  logic rst_n,
  input  logic acq,
  input  logic hit,
  output logic in_sync,
  output logic loss_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sync    <= 1'b0;
      loss_pulse <= 1'b0;
    end else begin
      loss_pulse <= hit & ~acq;
      if (acq)      in_sync <= 1'b1;
      else if (hit) in_sync <= 1'b0;
    end
  end
endmodule

// File: rtl/rds_sync_flywheel.sv
module rds_sync_flywheel
  import rds_fw_pkg::*;
#(
  parameter int         CNT_W     = RUN_W,
  parameter logic [3:0] RESET_CFG = 4'b0010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [3:0] cfg_val,
  input  logic       blk_stb,
  input  logic       blk_seq_ok,
  input  logic       blk_uncorr,
  input  logic       sync_acq,
  output logic       in_sync,
  output logic       loss_pulse
);
  // Named internal events, brought out for the checker.
  prot_cfg_t        cfg_q;
  logic [RUN_W-1:0] limit;
  logic             armed;
  logic             bad_evt;
  logic             good_evt;
  logic             hit_evt;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= prot_cfg_t'(RESET_CFG);
    else if (cfg_wr) cfg_q <= prot_cfg_t'(cfg_val);
  end

  always_comb begin
    limit = run_limit(cfg_q.run_code);
    armed = in_sync & ~sync_acq;
  end

  rds_fw_classify u_classify (
    .stb      (blk_stb),
    .armed    (armed),
    .cfg      (cfg_q),
    .seq_ok   (blk_seq_ok),
    .uncorr   (blk_uncorr),
    .bad_evt  (bad_evt),
    .good_evt (good_evt)
  );

  rds_fw_runcnt #(.CNT_W(CNT_W)) u_runcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sync_acq),
    .bad_evt  (bad_evt),
    .good_evt (good_evt),
    .limit    (limit),
    .cnt      (cnt_q),
    .hit      (hit_evt)
  );

  rds_fw_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq        (sync_acq),
    .hit        (hit_evt),
    .in_sync    (in_sync),
    .loss_pulse (loss_pulse)
  );
endmodule

// File: rtl/rds_fw_checker.sv
module rds_fw_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_acq,
  input logic             blk_stb,
  input logic             in_sync,
  input logic             loss_pulse,
  input logic             good_evt,
  input logic             bad_evt,
  input logic             hit_evt,
  input logic [CNT_W-1:0] cnt
);
  a_r5_good_clears: assert property (@(posedge clk) disable iff (!rst_n)
    good_evt |=> (cnt == '0));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    loss_pulse |=> !loss_pulse);

  a_r6_hit_drops_sync: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (loss_pulse && !in_sync));

  a_r7_lost_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |=> !loss_pulse);

  a_r7_lost_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |-> !(bad_evt || good_evt));

  a_r8_acq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sync_acq |=> (in_sync && !loss_pulse && cnt == '0));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_stb && !sync_acq) |=> ($stable(cnt) && $stable(in_sync)));

  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(15));
endmodule

bind rds_sync_flywheel rds_fw_checker #(.CNT_W(CNT_W)) u_fw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_acq   (sync_acq),
  .blk_stb    (blk_stb),
  .in_sync    (in_sync),
  .loss_pulse (loss_pulse),
  .good_evt   (good_evt),
  .bad_evt    (bad_evt),
  .hit_evt    (hit_evt),
  .cnt        (cnt_q)
);

// File: tb/test_rds_sync_flywheel.sv
module test_rds_sync_flywheel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_val = 4'd0;
  logic       blk_stb = 1'b0;
  logic       blk_seq_ok = 1'b0;
  logic       blk_uncorr = 1'b0;
  logic       sync_acq = 1'b0;
  logic       in_sync;
  logic       loss_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rds_sync_flywheel i_rds_sync_flywheel (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_val(cfg_val),
    .blk_stb(blk_stb), .blk_seq_ok(blk_seq_ok), .blk_uncorr(blk_uncorr),
    .sync_acq(sync_acq), .in_sync(in_sync), .loss_pulse(loss_pulse)
  );

  // Vector: {acq, stb, seq_ok, uncorr, exp_in_sync, exp_loss}, default setting.
  localparam int NV = 27;
  localparam logic [5:0] VEC [0:NV-1] = '{
    6'b100010,                                   // R8 acquire
    6'b010010, 6'b010010, 6'b010010, 6'b010010,  // four bad
    6'b011010,                                   // R5 good clears
    6'b011110,                                   // R2 uncorr ignored
    6'b010010, 6'b010010, 6'b010010, 6'b010010,  // four bad again
    6'b000010,                                   // R10 idle
    6'b010001,                                   // R1 fifth bad -> loss
    6'b000000,
    6'b010000, 6'b010000, 6'b010000, 6'b010000, 6'b010000, 6'b010000, // R7
    6'b110010,                                   // R8 acq with strobe
    6'b010010, 6'b010010, 6'b010010, 6'b010010,
    6'b010001,
    6'b000000
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {in_sync,loss_pulse} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic s, input logic q, input logic u);
    @(negedge clk);
    sync_acq = a; blk_stb = s; blk_seq_ok = q; blk_uncorr = u; cfg_wr = 1'b0;
    @(posedge clk);
    #1;
    sync_acq = 1'b0; blk_stb = 1'b0;
  endtask

  task automatic wcfg(input logic [3:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_val = v;
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
  endtask

  function automatic int lim(input logic [2:0] c);
    case (c)
      3'd0: return 3;  3'd1: return 4;  3'd2: return 5;  3'd3: return 6;
      3'd4: return 8;  3'd5: return 10; 3'd6: return 12; default: return 16;
    endcase
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", {in_sync, loss_pulse}, 2'b00);
    @(negedge clk) rst_n = 1'b1;

    // Vector walk under the reset setting (R1, R2, R5, R6, R7, R8, R10).
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R6 vector %0d", i), {in_sync, loss_pulse}, VEC[i][1:0]);
    end

    // R3: uncorrectable mode, run 5; seq_ok ignored.
    wcfg(4'b1010);
    step(1, 0, 0, 0);
    for (int k = 0; k < 6; k++) step(0, 1, 0, 0);
    chk("R3 seq_ok ignored", {in_sync, loss_pulse}, 2'b10);
    for (int k = 0; k < 4; k++) step(0, 1, 1, 1);
    chk("R3 four uncorrectable", {in_sync, loss_pulse}, 2'b10);
    step(0, 1, 1, 1);
    chk("R3 fifth uncorrectable", {in_sync, loss_pulse}, 2'b01);
    step(0, 0, 0, 0);
    chk("R6 pulse one cycle", {in_sync, loss_pulse}, 2'b00);

    // R4: every run code, both criteria.
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        wcfg({m[0], c[2:0]});
        step(1, 0, 0, 0);
        for (int k = 0; k < lim(c[2:0]) - 1; k++)
          step(0, 1, m[0], m[0]);
        chk($sformatf("R4 code %0d mode %0d before limit", c, m), {in_sync, loss_pulse}, 2'b10);
        step(0, 1, m[0], m[0]);
        chk($sformatf("R4 code %0d mode %0d at limit", c, m), {in_sync, loss_pulse}, 2'b01);
      end
    end

    // R9: lower the run length below the present count.
    wcfg(4'b0111);
    step(1, 0, 0, 0);
    for (int k = 0; k < 10; k++) step(0, 1, 0, 0);
    chk("R9 ten of sixteen", {in_sync, loss_pulse}, 2'b10);
    wcfg(4'b0000);
    chk("R9 write alone no loss", {in_sync, loss_pulse}, 2'b10);
    step(0, 1, 0, 0);
    chk("R9 next bad declares loss", {in_sync, loss_pulse}, 2'b01);

    summary();
  end
endmodule